// File: doc/BRIEF.md
# Token-Sequenced Accumulate Filter

This block is one streaming filter realised as a ring of four basic-block units. Control does not come from a central state counter. A one-hot control token moves from unit to unit, and only the unit that holds the token does any work. The first unit clears the running total and the loop index. The second unit takes one word from the input stream into a temporary. The third unit does three things in parallel: it adds the temporary to the total, increments the index, and compares the new index with the loop count. The compare picks the next unit: the token goes back to the second unit while the index is below the count, and on to the fourth unit once it reaches the count. The fourth unit offers the total on the output stream. When the output is taken, the token returns to the first unit and the filter starts its next frame.

Both stream ports are valid/ready. A word moves on a rising clock edge where valid and ready are both high. The input side raises `in_ready` only while the token sits in the read unit. The output side raises `out_valid` only while the token sits in the write unit. Each unit passes the token on only after its handshake completes, so back-pressure on either side stops the whole filter. Nothing is dropped and nothing is duplicated. With both sides always willing, a frame of `LOOP_COUNT` words takes `2*LOOP_COUNT+2` cycles.

Top module: `acc_token_filter`

## Requirements
- R1: While `rst_n` is low, `in_ready` and `out_valid` are both low. On the first clock edge after `rst_n` rises, the token moves from the clear unit to the read unit, so `in_ready` is high in the cycle that follows.
- R2: Exactly one output word is produced for every `LOOP_COUNT` (default 8) accepted input words. No output appears while fewer words of the current frame have been accepted.
- R3: The output word is the sum of the frame's input words, taken modulo 2^`DATA_W` (default 32 bits).
- R4: Exactly one unit holds the token at any time, and `in_ready` and `out_valid` are never high in the same cycle.
- R5: An input word is consumed only on an edge where `in_valid` and `in_ready` are both high. Idle gaps on `in_valid` neither add words nor drop any.
- R6: Once `out_valid` is high, it stays high and `out_data` stays unchanged until an edge where `out_ready` is high.
- R7: While the output is stalled (`out_valid` high, `out_ready` low), `in_ready` stays low and no input word is consumed, even with `in_valid` held high.
- R8: The total and the index restart at zero on every frame, so each output depends only on the words of its own frame.
- R9: After each accepted input word, `in_ready` is low for the next cycle while the update unit runs. With `in_valid` and `out_ready` held high, output handshakes are exactly `2*LOOP_COUNT+2` cycles apart (18 at the default).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; places the token in the clear unit |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Filter takes a word on this edge (read unit holds token) |
| in_data | input | DATA_W | Input word |
| out_valid | output | 1 | Sum word offered (write unit holds token) |
| out_ready | input | 1 | Downstream takes the sum on this edge |
| out_data | output | DATA_W | Frame sum |

## Verification
The read and write units can never be active together. The case that can fall in one cycle is a pending input word, with `in_valid` high, while the output is held back by `out_ready` low. The bench provokes it by finishing a frame with `out_ready` low and then raising `in_valid` with the first word of the next frame. It then confirms, over several cycles, that `in_ready` stays low, that the input accept count does not move, and that `out_data` holds. After `out_ready` is released, the sum must leave once, and the held word must become the first word of the next frame with the correct total.

// File: rtl/acc_tok_pkg.sv
package acc_tok_pkg;
  // Basic-block positions in the token ring
  localparam int NUM_BB  = 4;
  localparam int BB_INIT = 0;
  localparam int BB_POP  = 1;
  localparam int BB_UPD  = 2;
  localparam int BB_PUSH = 3;

  typedef logic [NUM_BB-1:0] tok_vec_t;
endpackage

// File: rtl/acc_bb_init.sv
module acc_bb_init #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_in,
  output logic              tok,
  output logic              go_out,
  output logic [DATA_W-1:0] sum_q,
  output logic [IDX_W-1:0]  idx_q
);
  // Single-cycle block: takes the token, clears live-outs, passes the token on
  assign go_out = tok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok   <= 1'b1;
      sum_q <= '0;
      idx_q <= '0;
    end else begin
      tok <= go_in;
      if (tok) begin
        sum_q <= '0;
        idx_q <= '0;
      end
    end
  end

  AST_INIT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    tok |=> !tok); // R4
endmodule

// File: rtl/acc_bb_pop.sv
module acc_bb_pop #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_init,
  input  logic              go_loop,
  input  logic [DATA_W-1:0] sum_init,
  input  logic [IDX_W-1:0]  idx_init,
  input  logic [DATA_W-1:0] sum_loop,
  input  logic [IDX_W-1:0]  idx_loop,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              go_out,
  output logic [DATA_W-1:0] sum_q,
  output logic [IDX_W-1:0]  idx_q,
  output logic [DATA_W-1:0] tmp_q
);
  logic              tok;
  logic              from_loop_q;
  logic              fire;
  logic [DATA_W-1:0] sum_sel;
  logic [IDX_W-1:0]  idx_sel;

  assign in_ready = tok;
  assign fire     = tok & in_valid;
  assign go_out   = fire;

  // Entry muxes: live-ins come from the clear block or from the update block
  assign sum_sel = from_loop_q ? sum_loop : sum_init;
  assign idx_sel = from_loop_q ? idx_loop : idx_init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok         <= 1'b0;
      from_loop_q <= 1'b0;
      sum_q       <= '0;
      idx_q       <= '0;
      tmp_q       <= '0;
    end else begin
      tok <= go_init | go_loop | (tok & ~fire);
      if (go_init)      from_loop_q <= 1'b0;
      else if (go_loop) from_loop_q <= 1'b1;
      if (fire) begin
        tmp_q <= in_data;
        sum_q <= sum_sel;
        idx_q <= idx_sel;
      end
    end
  end

  AST_POP_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_init && go_loop)); // R4
  AST_POP_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (go_init || go_loop) |-> !tok); // R4
  AST_POP_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R9
  AST_POP_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready); // R5
endmodule

// File: rtl/acc_bb_update.sv
module acc_bb_update #(
  parameter int DATA_W     = 32,
  parameter int IDX_W      = 4,
  parameter int LOOP_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_in,
  input  logic [DATA_W-1:0] sum_in,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic [DATA_W-1:0] tmp_in,
  output logic              go_loop,
  output logic              go_exit,
  output logic [DATA_W-1:0] sum_q,
  output logic [IDX_W-1:0]  idx_q
);
  localparam bit POW2_LIMIT = (LOOP_COUNT > 1) && ((LOOP_COUNT & (LOOP_COUNT - 1)) == 0);

  logic              tok;
  logic [DATA_W-1:0] sum_next;
  logic [IDX_W-1:0]  idx_next;
  logic              below;

  // Parallel functional units
  assign sum_next = sum_in + tmp_in;
  assign idx_next = idx_in + IDX_W'(1);

  generate
    if (POW2_LIMIT) begin : g_cmp_msb
      assign below = ~idx_next[IDX_W-1];
    end else begin : g_cmp_full
      assign below = idx_next < IDX_W'(LOOP_COUNT);
    end
  endgenerate

  // Predicated branch
  assign go_loop = tok & below;
  assign go_exit = tok & ~below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tok   <= 1'b0;
      sum_q <= '0;
      idx_q <= '0;
    end else begin
      tok <= go_in;
      if (tok) begin
        sum_q <= sum_next;
        idx_q <= idx_next;
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tok |-> (idx_in < IDX_W'(LOOP_COUNT))); // R2
  AST_EXIT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    go_exit |=> (idx_q == IDX_W'(LOOP_COUNT))); // R2
  AST_UPD_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    !(go_loop && go_exit)); // R4
endmodule

// File: rtl/acc_bb_push.sv
module acc_bb_push #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_in,
  input  logic [DATA_W-1:0] sum_in,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              go_out
);
  logic tok;

  assign out_valid = tok;
  assign out_data  = sum_in;
  assign go_out    = tok & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tok <= 1'b0;
    else        tok <= go_in | (tok & ~out_ready);
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6
endmodule

// File: rtl/acc_token_filter.sv
module acc_token_filter #(
  parameter int DATA_W     = 32,
  parameter int LOOP_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import acc_tok_pkg::*;

  localparam int IDX_W = $clog2(LOOP_COUNT + 1);

  tok_vec_t          tok_all;
  logic              tok_init;
  logic              go_init_pop, go_pop_upd, go_upd_pop, go_upd_push, go_push_init;
  logic [DATA_W-1:0] sum_init, sum_pop, sum_upd, tmp_pop;
  logic [IDX_W-1:0]  idx_init, idx_pop, idx_upd;
  logic              upd_busy;

  acc_bb_init #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_init (
    .clk(clk), .rst_n(rst_n), .go_in(go_push_init), .tok(tok_init),
    .go_out(go_init_pop), .sum_q(sum_init), .idx_q(idx_init)
  );

  acc_bb_pop #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_pop (
    .clk(clk), .rst_n(rst_n), .go_init(go_init_pop), .go_loop(go_upd_pop),
    .sum_init(sum_init), .idx_init(idx_init), .sum_loop(sum_upd), .idx_loop(idx_upd),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .go_out(go_pop_upd),
    .sum_q(sum_pop), .idx_q(idx_pop), .tmp_q(tmp_pop)
  );

  acc_bb_update #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LOOP_COUNT(LOOP_COUNT)) u_upd (
    .clk(clk), .rst_n(rst_n), .go_in(go_pop_upd), .sum_in(sum_pop), .idx_in(idx_pop),
    .tmp_in(tmp_pop), .go_loop(go_upd_pop), .go_exit(go_upd_push),
    .sum_q(sum_upd), .idx_q(idx_upd)
  );

  acc_bb_push #(.DATA_W(DATA_W)) u_push (
    .clk(clk), .rst_n(rst_n), .go_in(go_upd_push), .sum_in(sum_upd),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .go_out(go_push_init)
  );

  // Update block holds the token exactly when it is resolving a branch
  assign upd_busy         = go_upd_pop | go_upd_push;
  assign tok_all[BB_INIT] = tok_init;
  assign tok_all[BB_POP]  = in_ready;
  assign tok_all[BB_UPD]  = upd_busy;
  assign tok_all[BB_PUSH] = out_valid;

  AST_ONE_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tok_all) == 1); // R4
  AST_NO_POP_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R4
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !in_ready); // R7
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> tok_init); // R8
endmodule

// File: tb/acc_token_filter_test.sv
module acc_token_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 32;
  localparam int LOOP_COUNT = 8;
  localparam int WATCHDOG   = 50000;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [DATA_W-1:0] in_data;
  logic              out_valid;
  logic              out_ready;
  logic [DATA_W-1:0] out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int in_acc = 0;
  int out_cnt = 0;
  logic [DATA_W-1:0] out_log [64];
  int out_stamp [64];

  acc_token_filter #(.DATA_W(DATA_W), .LOOP_COUNT(LOOP_COUNT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc++;

  // Handshake monitor, sampled late in the cycle, well away from both edges
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      if (in_valid && in_ready) in_acc++;
      if (out_valid && out_ready) begin
        out_log[out_cnt % 64]   = out_data;
        out_stamp[out_cnt % 64] = cyc;
        out_cnt++;
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    forever begin
      #1;
      if (in_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle_in();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_outputs(input int n);
    while (out_cnt < n) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 in_ready in reset", in_ready, 0);
    check("R1 out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 in_ready after release", in_ready, 1);
  endtask

  task automatic t_basic();
    int base = out_cnt;
    int acc0 = in_acc;
    out_ready = 1'b1;
    for (int i = 1; i <= 16; i++) send_word(DATA_W'(i));
    idle_in();
    wait_outputs(base + 2);
    check("R2 first frame sum", out_log[base % 64], 36);
    check("R8 second frame sum", out_log[(base + 1) % 64], 100);
    check("R9 frame period", out_stamp[(base + 1) % 64] - out_stamp[base % 64], 2*LOOP_COUNT + 2);
    repeat (30) @(negedge clk);
    check("R2 outputs per 16 words", out_cnt - base, 2);
    check("R5 words accepted", in_acc - acc0, 16);
  endtask

  task automatic t_wrap();
    int base = out_cnt;
    out_ready = 1'b1;
    for (int i = 0; i < 8; i++) send_word(32'hFFFF_FFFF);
    idle_in();
    wait_outputs(base + 1);
    check("R3 wrapped sum", out_log[base % 64], 32'hFFFF_FFF8);
  endtask

  task automatic t_gaps();
    int base = out_cnt;
    int acc0 = in_acc;
    out_ready = 1'b1;
    for (int i = 0; i < 7; i++) begin
      send_word(DATA_W'(100 * (i + 1)));
      idle_in();
      repeat (i % 3 + 1) @(negedge clk);
    end
    repeat (10) @(negedge clk);
    #1;
    check("R2 no output after 7 words", out_cnt - base, 0);
    check("R2 out_valid low after 7 words", out_valid, 0);
    check("R5 gapped words counted", in_acc - acc0, 7);
    send_word(DATA_W'(5));
    idle_in();
    wait_outputs(base + 1);
    check("R3 gapped frame sum", out_log[base % 64], 2805);
  endtask

  task automatic t_stall();
    int base = out_cnt;
    int acc0;
    out_ready = 1'b0;
    for (int i = 10; i < 18; i++) send_word(DATA_W'(i));
    idle_in();
    while (!out_valid) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DATA_W'(5);
    acc0 = in_acc;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      #1;
      check("R6 out_valid held", out_valid, 1);
      check("R6 out_data held", out_data, 108);
      check("R7 in_ready low in stall", in_ready, 0);
    end
    #(CLK_PERIOD/2);
    check("R7 no word taken in stall", in_acc - acc0, 0);
    @(negedge clk);
    out_ready = 1'b1;
    send_word(DATA_W'(5));
    for (int i = 0; i < 7; i++) send_word(DATA_W'(1));
    idle_in();
    wait_outputs(base + 2);
    check("R6 stalled sum delivered once", out_log[base % 64], 108);
    check("R8 held word starts next frame", out_log[(base + 1) % 64], 12);
    repeat (20) @(negedge clk);
    check("R2 outputs after stall", out_cnt - base, 2);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wrap();
    t_gaps();
    t_stall();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule